// File: doc/BRIEF.md
# Prescaled Auto-Reload Tick Timer

This block produces a slow, regular time base from a 32.768 kHz reference. The reference arrives as a one-cycle enable pulse on the system clock. A free-running prescaler turns it into a slower count enable by dividing by a power of two, from 1 up to 32. The divided enable steps a 16-bit down-counter. When the counter has reached zero, the next enable reloads it from a programmable reload register. The tick output is high for as long as the counter holds zero, which is exactly one prescaled period. With reload value N, one full period lasts N+1 prescaled periods. The tick is meant to drive an interrupt controller as a system tick.

Software programs the block through single-cycle register writes. It sets the prescale exponent, the reload value and a self-clearing restart bit. A status output stays high while a reload-register write or a restart has not yet been absorbed. Rewriting the reload value leaves the running count alone; the new value is first used at the next load. The block has no data stream, so every pin is a plain level or pulse and none has a handshake.

Top module: `lftick_timer`

## Requirements
- R1: Reset state. The counter holds 0xFFFF, the tick is low, the status is low, the exponent is 0 and the reload register holds 0xFFFF.
- R2: Prescaler. A 5-bit phase counter counts every `lf_en` pulse from reset. With exponent E, a prescaled event happens in an `lf_en` cycle whose phase value has its low E bits all set, so events come once per 2^E reference pulses.
- R3: A write to address 0 sets the exponent from `wr_data[2:0]`. A value above 5 is stored as 5. The new exponent applies from the next cycle.
- R4: On a prescaled event, the counter decrements by one if it is non-zero. If it is zero, it loads the reload register instead. The period is therefore reload+1 events. Between events the counter does not change.
- R5: `tick` is high in exactly those cycles in which `count` is zero.
- R6: A write to address 1 stores `wr_data` as the reload value and leaves the current count untouched. A load in the same cycle as the write still uses the previous reload value.
- R7: A write to address 2 with `wr_data[0]`=1 sets a restart request. At the next prescaled event after the write cycle, the counter loads the reload value, whatever the count is, and the request clears. A write to address 2 with bit 0 low has no effect.
- R8: `load_busy` is high while a restart request is set, or while a reload write is unabsorbed. A reload write is absorbed at the first `lf_en` cycle after the write cycle.
- R9: With a reload value of 0, once loaded the counter stays at zero and `tick` stays high continuously.
- R10: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address: 0 exponent, 1 reload, 2 control |
| wr_data | input | 16 | Write data |
| tick | output | 1 | High while the counter is zero |
| count | output | 16 | Current counter value |
| load_busy | output | 1 | A reload write or a restart is still pending |

## Verification
Two functions can land in one cycle. A restart request or a reload write can coincide with a prescaled event at which the counter also wraps through zero. An exponent write can also coincide with the reference pulse whose phase it decides. The bench issues restart and reload writes at a sweep of offsets against a reference pulse that runs freely every three clocks, so some writes fall exactly on event cycles and on zero-wrap cycles. A behavioural model applies the ordering rules of R6, R7 and R8. Count, tick and status are compared with that model on every cycle.

// File: rtl/lftick_pkg.sv
package lftick_pkg;
  localparam int CNT_W   = 16;
  localparam int EXP_MAX = 5;
  localparam int EXP_W   = $clog2(EXP_MAX + 1);
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_EXP    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_RESTART_BIT = 0;
endpackage

// File: rtl/lftick_prescale.sv
module lftick_prescale #(
  parameter int EXP_MAX = 5,
  parameter int EXP_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_en,
  input  logic [EXP_W-1:0] exp_i,
  output logic             t0_en
);
  localparam int PRE_W = EXP_MAX;

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  // Bit i of the mask takes part in the match when the exponent exceeds i.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (exp_i > EXP_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (lf_en) begin
      phase_q <= phase_q + PRE_W'(1);
    end
  end

  assign t0_en = lf_en && ((phase_q & mask) == mask);
endmodule

// File: rtl/lftick_regs.sv
module lftick_regs
  import lftick_pkg::*;
#(
  parameter int W      = 16,
  parameter int EXP_LIM = 5,
  parameter int EW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_en,
  input  logic              t0_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [EW-1:0]     exp_q,
  output logic [W-1:0]      reload_q,
  output logic              rst_pend,
  output logic              ld_pend
);
  logic          wr_exp, wr_rel, wr_rst;
  logic [EW-1:0] exp_in;

  assign wr_exp = wr_en && (wr_addr == ADDR_EXP);
  assign wr_rel = wr_en && (wr_addr == ADDR_RELOAD);
  assign wr_rst = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_RESTART_BIT];
  assign exp_in = (wr_data[EW-1:0] > EW'(EXP_LIM)) ? EW'(EXP_LIM) : wr_data[EW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q    <= '0;
      reload_q <= '1;
      rst_pend <= 1'b0;
      ld_pend  <= 1'b0;
    end else begin
      if (wr_exp) exp_q <= exp_in;

      if (wr_rel) begin
        reload_q <= wr_data;
        ld_pend  <= 1'b1;
      end else if (lf_en) begin
        ld_pend  <= 1'b0;
      end

      if (wr_rst)     rst_pend <= 1'b1;
      else if (t0_en) rst_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/lftick_count.sv
module lftick_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         t0_en,
  input  logic         rst_pend,
  input  logic [W-1:0] reload_q,
  output logic [W-1:0] count_q,
  output logic         tick
);
  logic at_zero;
  assign at_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '1;
    end else if (t0_en) begin
      if (rst_pend || at_zero) count_q <= reload_q;
      else                     count_q <= count_q - W'(1);
    end
  end

  assign tick = at_zero;
endmodule

// File: rtl/lftick_timer.sv
module lftick_timer
  import lftick_pkg::*;
#(
  parameter int CNT_W_P   = CNT_W,
  parameter int EXP_MAX_P = EXP_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lf_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W_P-1:0] wr_data,
  output logic               tick,
  output logic [CNT_W_P-1:0] count,
  output logic               load_busy
);
  localparam int EW = $clog2(EXP_MAX_P + 1);

  logic [EW-1:0]      exp_q;
  logic [CNT_W_P-1:0] reload_q;
  logic               rst_pend, ld_pend, t0_en;

  lftick_prescale #(.EXP_MAX(EXP_MAX_P), .EXP_W(EW)) u_pre (
    .clk(clk), .rst_n(rst_n), .lf_en(lf_en), .exp_i(exp_q), .t0_en(t0_en)
  );

  lftick_regs #(.W(CNT_W_P), .EXP_LIM(EXP_MAX_P), .EW(EW)) u_regs (
    .clk(clk), .rst_n(rst_n), .lf_en(lf_en), .t0_en(t0_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .exp_q(exp_q), .reload_q(reload_q), .rst_pend(rst_pend), .ld_pend(ld_pend)
  );

  lftick_count #(.W(CNT_W_P)) u_cnt (
    .clk(clk), .rst_n(rst_n), .t0_en(t0_en), .rst_pend(rst_pend),
    .reload_q(reload_q), .count_q(count), .tick(tick)
  );

  assign load_busy = rst_pend | ld_pend;
endmodule

// File: rtl/lftick_checker.sv
module lftick_checker #(
  parameter int W  = 16,
  parameter int EW = 3,
  parameter int EL = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lf_en,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic         t0_en,
  input logic         rst_pend,
  input logic         ld_pend,
  input logic [EW-1:0] exp_q,
  input logic [W-1:0] reload_q,
  input logic [W-1:0] count
);
  a_r3_exp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q <= EW'(EL));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_en && !rst_pend && count != '0) |=> count == $past(count) - W'(1));

  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_en && count == '0) |=> count == $past(reload_q));

  a_r4_hold_between_events: assert property (@(posedge clk) disable iff (!rst_n)
    !t0_en |=> $stable(count));

  a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_en && rst_pend) |=> count == $past(reload_q));

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_en && rst_pend && !(wr_en && wr_addr == 2'd2)) |=> !rst_pend);

  a_r8_pend_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pend && lf_en && !(wr_en && wr_addr == 2'd1)) |=> !ld_pend);
endmodule

bind lftick_timer lftick_checker #(.W(CNT_W_P), .EW(EW), .EL(EXP_MAX_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .lf_en(lf_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .t0_en(t0_en), .rst_pend(rst_pend), .ld_pend(ld_pend), .exp_q(exp_q),
  .reload_q(reload_q), .count(count)
);

// File: tb/lftick_timer_bench.sv
module lftick_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LF_GAP     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick;
  logic [15:0] count;
  logic        load_busy;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    running = 0;
  bit    done = 0;

  // behavioural reference state
  int m_phase, m_exp, m_reload, m_cnt;
  bit m_ld, m_rst;

  lftick_timer u_lftick_timer (
    .clk(clk), .rst_n(rst_n), .lf_en(lf_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .count(count), .load_busy(load_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_exp = 0; m_reload = 16'hFFFF; m_cnt = 16'hFFFF;
      m_ld = 0; m_rst = 0;
    end else begin
      int  mk;
      bit  ev;
      mk = (1 << m_exp) - 1;
      ev = lf_en && ((m_phase & mk) == mk);
      if (ev) begin
        if (m_rst || m_cnt == 0) m_cnt = m_reload;
        else m_cnt = m_cnt - 1;
      end
      if (lf_en) m_phase = (m_phase + 1) % 32;
      if (wr_en && wr_addr == 2'd0) m_exp = (wr_data[2:0] > 5) ? 5 : int'(wr_data[2:0]);
      if (wr_en && wr_addr == 2'd1) begin m_reload = wr_data; m_ld = 1; end
      else if (lf_en) m_ld = 0;
      if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_rst = 1;
      else if (ev) m_rst = 0;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      check(tag, "count", count, m_cnt);
      check(tag, "load_busy", load_busy, (m_ld || m_rst) ? 1 : 0);
      check("R5", "tick vs zero count", tick, (count == 16'h0) ? 1 : 0);
    end
  end

  initial begin : lf_gen
    int div = 0;
    forever begin
      @(negedge clk);
      lf_en <= (div == 0);
      div = (div + 1) % LF_GAP;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n <= 1'b1;
    @(negedge clk);
    // R1: literal reset values
    check("R1", "count after reset", count, 16'hFFFF);
    check("R1", "tick after reset", tick, 0);
    check("R1", "busy after reset", load_busy, 0);
    running = 1;

    tag = "R4";
    wr(2'd1, 16'd3);
    // R8: one cycle after a reload write the status must be high
    check("R8", "busy after reload write", load_busy, 1);
    wr(2'd2, 16'h0001);
    idle(120);

    tag = "R2";
    wr(2'd0, 16'd2); idle(200);
    wr(2'd0, 16'd5); idle(900);
    wr(2'd0, 16'd1); idle(100);

    tag = "R3";
    wr(2'd0, 16'd7); idle(800);
    wr(2'd0, 16'd6); idle(400);
    wr(2'd0, 16'd0);

    tag = "R6";
    wr(2'd1, 16'd40); idle(30);
    wr(2'd1, 16'd2);  idle(200);

    tag = "R7";
    for (int off = 0; off < 14; off++) begin
      wr(2'd2, 16'h0001);
      idle(off);
    end
    wr(2'd2, 16'h0000); idle(10);
    wr(2'd2, 16'h0002); idle(10);
    for (int off = 0; off < 10; off++) begin
      wr(2'd1, 16'(off % 4));
      wr(2'd2, 16'h0001);
      idle(off);
    end

    tag = "R9";
    wr(2'd1, 16'd0); wr(2'd2, 16'h0001); idle(12);
    repeat (30) begin
      @(negedge clk);
      check("R9", "tick held with zero reload", tick, 1);
    end

    tag = "R10";
    wr(2'd1, 16'd5); idle(30);
    wr(2'd3, 16'h00FF); idle(60);

    running = 0;
    finish_run();
  end
endmodule